// File: doc/BRIEF.md
# Shadowed Timekeeping Register Front End

This block sits between a byte-level serial bus target and a free-running clock/calendar core. It holds a secondary copy of the seven time registers: seconds, minutes, hours, day-of-week, date, month/century and year, at addresses 0 to 6. All bus reads come from this copy, so a multibyte read is coherent even though the live counters keep advancing underneath it.

The copy is refreshed from the live counters in one step on every bus START and each time the auto-incrementing register pointer wraps from the last address back to 0. If the core updates its counters in the same cycle as a refresh request, the refresh waits one cycle and takes the post-update values, so no field is torn. Bus writes bypass the copy. Each acknowledged data byte drives a registered one-hot write enable and data into the core. A write to the seconds address also gives a one-cycle strobe that clears the core's sub-second chain.

The bit-level bus engine supplies event pulses: a START, an acknowledged write-direction device address, an acknowledged data byte with its value, and a transferred read byte. The front end returns the read byte for the current pointer.

Top module: `tkr_front`

## Requirements
- R1: After reset the pointer is 0, the shadow copy is all zero, `rd_data_o` is 0, and `wr_en_o` and `sec_rst_o` are 0.
- R2: The first data byte after `addr_wr_i` loads the pointer and produces no write enable. A value of 7 or more loads 0.
- R3: Every later data byte, written or read, advances the pointer by one, and address 6 advances to 0.
- R4: A `start_i` pulse with no tick in that cycle copies all seven live bytes into the shadow at that clock edge. From the next cycle, `rd_data_o` shows the shadow byte at the pointer (byte k of `live_time_i` is bits 8k+7..8k).
- R5: With no START and no wrap, the shadow and `rd_data_o` stay unchanged while `live_time_i` changes.
- R6: An advance of the pointer from 6 to 0 copies the live bytes into the shadow at that same edge.
- R7: A copy request in a cycle with `live_tick_i` high is deferred. The shadow is loaded at the first later edge where the tick is low, so it gets the post-tick values.
- R8: A non-pointer data byte makes `wr_en_o` one-hot at the pointer's bit in the following cycle, for one cycle, with `wr_data_o` equal to the byte. The shadow is not altered by writes.
- R9: `sec_rst_o` pulses for exactly that cycle when the write targets address 0, and is low for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Bus START seen (pulse) |
| addr_wr_i | input | 1 | Write-direction device address acknowledged (pulse) |
| wr_byte_i | input | 1 | Data byte acknowledged from the bus (pulse) |
| wr_data_i | input | 8 | Value of the acknowledged data byte |
| rd_byte_i | input | 1 | Read byte transferred to the bus (pulse) |
| rd_data_o | output | 8 | Shadow byte at the current pointer |
| live_time_i | input | 56 | Live counter bytes from the core, address k at bits 8k+7..8k |
| live_tick_i | input | 1 | Core updates its counters at the end of this cycle |
| wr_en_o | output | 7 | One-hot write enable per register into the core |
| wr_data_o | output | 8 | Write data into the core |
| sec_rst_o | output | 1 | Sub-second chain clear on a seconds write |

## Verification
Every pointer load value from 0 to 9 is followed by a nine-byte read run. This covers both wrap positions and the mapping of out-of-range loads to 0. The live inputs change after each START, so a stale shadow byte can be told apart from a freshly copied one. Read bytes after the wrap must show the newer values. Nine consecutive writes after a load of 5 cross the wrap and check the enable position, the data and the seconds strobe at each address. Reads that follow show that written bytes did not enter the shadow. A START that coincides with a tick is checked both before and after the deferred copy, which separates pre-tick values from post-tick values.

// File: rtl/tkr_pkg.sv
package tkr_pkg;
  localparam int TKR_NUM_REGS = 7;
  localparam int TKR_DW       = 8;
  localparam int TKR_SEC_ADDR = 0;

  typedef enum logic [0:0] {PH_DATA = 1'b0, PH_PTR = 1'b1} tkr_phase_e;
endpackage

// File: rtl/tkr_ptr.sv
module tkr_ptr
  import tkr_pkg::*;
#(
  parameter int NUM_REGS = TKR_NUM_REGS,
  parameter int DW       = TKR_DW,
  parameter int AW       = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          addr_wr_i,
  input  logic          wr_byte_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_byte_i,
  output logic [AW-1:0] ptr_o,
  output logic          wrap_o,
  output logic          data_wr_o
);
  localparam logic [AW-1:0] LAST = AW'(NUM_REGS - 1);

  tkr_phase_e    phase_q;
  logic [AW-1:0] ptr_q;
  logic          step;
  logic          in_range;

  assign data_wr_o = wr_byte_i && (phase_q == PH_DATA);
  assign step      = rd_byte_i || data_wr_o;
  assign wrap_o    = step && (ptr_q == LAST);
  assign in_range  = wr_data_i < DW'(NUM_REGS);
  assign ptr_o     = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_DATA;
      ptr_q   <= '0;
    end else begin
      if (addr_wr_i) phase_q <= PH_PTR;
      else if (start_i || rd_byte_i || wr_byte_i) phase_q <= PH_DATA;

      if (wr_byte_i && phase_q == PH_PTR) ptr_q <= in_range ? wr_data_i[AW-1:0] : '0;
      else if (step) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/tkr_shadow.sv
module tkr_shadow
  import tkr_pkg::*;
#(
  parameter int NUM_REGS = TKR_NUM_REGS,
  parameter int DW       = TKR_DW
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   snap_req_i,
  input  logic                   tick_i,
  input  logic [NUM_REGS*DW-1:0] live_i,
  output logic [NUM_REGS*DW-1:0] snap_o,
  output logic                   pend_o
);
  logic pend_q;
  logic want;
  logic take;

  // a copy never lands on a tick edge: it waits for settled counters
  assign want   = snap_req_i || pend_q;
  assign take   = want && !tick_i;
  assign pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= want && tick_i;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DW-1:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   byte_q <= '0;
      else if (take) byte_q <= live_i[g*DW +: DW];
    end
    assign snap_o[g*DW +: DW] = byte_q;
  end
endmodule

// File: rtl/tkr_wr_dec.sv
module tkr_wr_dec
  import tkr_pkg::*;
#(
  parameter int NUM_REGS = TKR_NUM_REGS,
  parameter int DW       = TKR_DW,
  parameter int AW       = 3,
  parameter int SEC_ADDR = TKR_SEC_ADDR
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                data_wr_i,
  input  logic [AW-1:0]       ptr_i,
  input  logic [DW-1:0]       wr_data_i,
  output logic [NUM_REGS-1:0] wr_en_o,
  output logic [DW-1:0]       wr_data_o,
  output logic                sec_rst_o
);
  logic [NUM_REGS-1:0] hit;
  logic [NUM_REGS-1:0] en_q;
  logic [DW-1:0]       data_q;
  logic                sec_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
    assign hit[g] = data_wr_i && (ptr_i == AW'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      data_q <= '0;
      sec_q  <= 1'b0;
    end else begin
      en_q  <= hit;
      sec_q <= hit[SEC_ADDR];
      if (data_wr_i) data_q <= wr_data_i;
    end
  end

  assign wr_en_o   = en_q;
  assign wr_data_o = data_q;
  assign sec_rst_o = sec_q;
endmodule

// File: rtl/tkr_front.sv
module tkr_front
  import tkr_pkg::*;
#(
  parameter int NUM_REGS = TKR_NUM_REGS,
  parameter int DW       = TKR_DW,
  parameter int SEC_ADDR = TKR_SEC_ADDR
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   addr_wr_i,
  input  logic                   wr_byte_i,
  input  logic [DW-1:0]          wr_data_i,
  input  logic                   rd_byte_i,
  output logic [DW-1:0]          rd_data_o,
  input  logic [NUM_REGS*DW-1:0] live_time_i,
  input  logic                   live_tick_i,
  output logic [NUM_REGS-1:0]    wr_en_o,
  output logic [DW-1:0]          wr_data_o,
  output logic                   sec_rst_o
);
  localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [AW-1:0]          ptr_w;
  logic                   wrap_w;
  logic                   data_wr_w;
  logic                   pend_w;
  logic [NUM_REGS*DW-1:0] snap_w;

  tkr_ptr #(.NUM_REGS(NUM_REGS), .DW(DW), .AW(AW)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .addr_wr_i (addr_wr_i),
    .wr_byte_i (wr_byte_i),
    .wr_data_i (wr_data_i),
    .rd_byte_i (rd_byte_i),
    .ptr_o     (ptr_w),
    .wrap_o    (wrap_w),
    .data_wr_o (data_wr_w)
  );

  tkr_shadow #(.NUM_REGS(NUM_REGS), .DW(DW)) u_shadow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .snap_req_i (start_i || wrap_w),
    .tick_i     (live_tick_i),
    .live_i     (live_time_i),
    .snap_o     (snap_w),
    .pend_o     (pend_w)
  );

  tkr_wr_dec #(.NUM_REGS(NUM_REGS), .DW(DW), .AW(AW), .SEC_ADDR(SEC_ADDR)) u_wr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .data_wr_i (data_wr_w),
    .ptr_i     (ptr_w),
    .wr_data_i (wr_data_i),
    .wr_en_o   (wr_en_o),
    .wr_data_o (wr_data_o),
    .sec_rst_o (sec_rst_o)
  );

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (ptr_w == AW'(i)) rd_data_o = snap_w[i*DW +: DW];
    end
  end
endmodule

// File: rtl/tkr_front_chk.sv
module tkr_front_chk #(
  parameter int NUM_REGS = 7,
  parameter int DW       = 8,
  parameter int SEC_ADDR = 0,
  parameter int AW       = 3
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   start_i,
  input logic                   wr_byte_i,
  input logic [DW-1:0]          wr_data_i,
  input logic                   rd_byte_i,
  input logic [NUM_REGS*DW-1:0] live_time_i,
  input logic                   live_tick_i,
  input logic [NUM_REGS-1:0]    wr_en_o,
  input logic [DW-1:0]          wr_data_o,
  input logic                   sec_rst_o,
  input logic [AW-1:0]          ptr_i,
  input logic [NUM_REGS*DW-1:0] snap_i,
  input logic                   pend_i
);
  assert_ptr_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_i < AW'(NUM_REGS));

  assert_start_snap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !live_tick_i) |=> snap_i == $past(live_time_i));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !rd_byte_i && !wr_byte_i && !pend_i) |=> $stable(snap_i));

  assert_wrap_snap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_byte_i && !wr_byte_i && !live_tick_i && ptr_i == AW'(NUM_REGS - 1))
      |=> (ptr_i == '0 && snap_i == $past(live_time_i)));

  assert_tick_defer_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && live_tick_i) |=> (pend_i && $stable(snap_i)));

  assert_wr_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en_o));

  assert_wr_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_en_o) |-> ($past(wr_byte_i) && wr_data_o == $past(wr_data_i)));

  assert_sec_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_rst_o |-> wr_en_o[SEC_ADDR]);

  assert_sec_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_rst_o |=> !sec_rst_o);
endmodule

bind tkr_front tkr_front_chk #(
  .NUM_REGS (NUM_REGS),
  .DW       (DW),
  .SEC_ADDR (SEC_ADDR),
  .AW       (AW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .wr_byte_i   (wr_byte_i),
  .wr_data_i   (wr_data_i),
  .rd_byte_i   (rd_byte_i),
  .live_time_i (live_time_i),
  .live_tick_i (live_tick_i),
  .wr_en_o     (wr_en_o),
  .wr_data_o   (wr_data_o),
  .sec_rst_o   (sec_rst_o),
  .ptr_i       (ptr_w),
  .snap_i      (snap_w),
  .pend_i      (pend_w)
);

// File: tb/sim_tkr_front.sv
module sim_tkr_front;
  localparam int NR = 7;
  localparam int DW = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic             addr_wr_i = 1'b0;
  logic             wr_byte_i = 1'b0;
  logic [DW-1:0]    wr_data_i = '0;
  logic             rd_byte_i = 1'b0;
  logic [DW-1:0]    rd_data_o;
  logic [NR*DW-1:0] live_time_i = '0;
  logic             live_tick_i = 1'b0;
  logic [NR-1:0]    wr_en_o;
  logic [DW-1:0]    wr_data_o;
  logic             sec_rst_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] live_m [NR];
  logic [7:0] exp_sh [NR];
  int eptr = 0;

  always #10 clk_i = ~clk_i;

  tkr_front u0 (
    .clk_i, .rst_ni, .start_i, .addr_wr_i, .wr_byte_i, .wr_data_i, .rd_byte_i,
    .rd_data_o, .live_time_i, .live_tick_i, .wr_en_o, .wr_data_o, .sec_rst_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic set_live(input int seed);
    for (int i = 0; i < NR; i++) begin
      live_m[i] = 8'((seed * 37 + i * 11 + 5) & 255);
      live_time_i[i*DW +: DW] = live_m[i];
    end
  endtask

  task automatic take_copy();
    for (int i = 0; i < NR; i++) exp_sh[i] = live_m[i];
  endtask

  task automatic do_start();
    start_i = 1'b1; cyc(); start_i = 1'b0;
    take_copy();
  endtask

  task automatic load_ptr(input int p);
    addr_wr_i = 1'b1; cyc(); addr_wr_i = 1'b0;
    wr_byte_i = 1'b1; wr_data_i = 8'(p); cyc(); wr_byte_i = 1'b0;
    chk("R2 no write on pointer byte", 32'(wr_en_o), 0);
    eptr = (p < NR) ? p : 0;
  endtask

  task automatic rbyte();
    chk("R3/R5 read byte", 32'(rd_data_o), 32'(exp_sh[eptr]));
    rd_byte_i = 1'b1; cyc(); rd_byte_i = 1'b0;
    eptr = (eptr == NR - 1) ? 0 : eptr + 1;
    if (eptr == 0) begin
      take_copy();
      chk("R6 copy on wrap", 32'(rd_data_o), 32'(exp_sh[0]));
    end
  endtask

  task automatic wbyte(input logic [7:0] d);
    wr_byte_i = 1'b1; wr_data_i = d; cyc(); wr_byte_i = 1'b0;
    chk("R8 enable", 32'(wr_en_o), 32'(1) << eptr);
    chk("R8 data", 32'(wr_data_o), 32'(d));
    chk("R9 seconds strobe", 32'(sec_rst_o), (eptr == 0) ? 1 : 0);
    cyc();
    chk("R8 enable one cycle", 32'(wr_en_o), 0);
    chk("R9 strobe one cycle", 32'(sec_rst_o), 0);
    eptr = (eptr == NR - 1) ? 0 : eptr + 1;
    if (eptr == 0) take_copy();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    set_live(0);
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 rd_data", 32'(rd_data_o), 0);
    chk("R1 wr_en", 32'(wr_en_o), 0);
    chk("R1 sec_rst", 32'(sec_rst_o), 0);
    rst_ni = 1'b1;
    cyc();
    chk("R1 rd_data after release", 32'(rd_data_o), 0);

    // R2 R3 R4 R5 R6: every load value, read across the wrap
    for (int p = 0; p < 10; p++) begin
      set_live(p + 1);
      do_start();
      load_ptr(p);
      do_start();
      chk("R4 copy on start", 32'(rd_data_o), 32'(exp_sh[eptr]));
      set_live(p + 100);
      for (int k = 0; k < 9; k++) rbyte();
    end

    // R8 R9: writes across the wrap; shadow untouched
    set_live(50);
    do_start();
    load_ptr(5);
    set_live(60);
    for (int k = 0; k < 9; k++) wbyte(8'(8'hA0 + k));
    for (int k = 0; k < NR; k++) rbyte();

    // R7: START with tick is deferred to post-tick values
    set_live(70);
    do_start();
    set_live(71);
    start_i = 1'b1; live_tick_i = 1'b1; cyc();
    start_i = 1'b0; live_tick_i = 1'b0;
    chk("R7 no copy on tick edge", 32'(rd_data_o), 32'(exp_sh[eptr]));
    set_live(72);
    cyc();
    take_copy();
    chk("R7 post-tick copy", 32'(rd_data_o), 32'(exp_sh[eptr]));
    for (int k = 0; k < NR; k++) rbyte();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule